// File: doc/BRIEF.md
# Interrupt Acknowledge Unit

This unit is the acknowledge path on the processor side of an interrupt controller. It keeps per-core interrupt state locally: a pending bit, an active bit, an edge/level handling bit, an enable and a priority for each local interrupt. It also keeps a register with one bit per priority level that records which priorities are currently active. Every cycle it works out the most urgent interrupt that is ready to be taken. The candidates are its own local interrupts and a single candidate offered by the external distributor for shared and message interrupts.

Software reads an acknowledge in one of two variants, normal or NMI. The unit answers with a result word and, on success, takes the winning interrupt. A local winner becomes active at once, and an edge-mode local winner also loses its pending bit. A shared or message winner is handed to the distributor as a single activate command. The distributor then sets the interrupt active and clears its pending bit where that applies, as one indivisible step. In that case the answer is held back until the command has been accepted.

Top module: `irq_ack_unit`

## Requirements
- R1: The result word carries the interrupt ID in bits 23:0, the type in bits 31:29 and a valid flag in bit 32. All other bits are 0. The type codes are 1 for a local interrupt, 2 for a message interrupt and 3 for a shared interrupt.
- R2: After reset, all local state, the active-priority register and both output valids are 0. A normal or NMI request taken while no command is outstanding gives a one-cycle `ack_valid` pulse on the next clock, except when the winner is external.
- R3: If no interrupt is eligible, the answer is the all-zero word and no state changes.
- R4: The winner is chosen from the local interrupts that are pending, enabled and not active, together with the external candidate. The lowest priority value wins. Between local interrupts of equal priority the lowest ID wins. At equal priority a local interrupt beats the external candidate.
- R5: A winner is eligible only if its priority is strictly lower in value than the running priority. The running priority is the lowest set bit of the active-priority register, or 32 (idle) when that register is zero.
- R6: A winner is an NMI when its priority is 0 and `nmi_en` is 1. The normal request takes only non-NMI winners and the NMI request takes only NMI winners. On a mismatch the answer is zero and no state changes.
- R7: A successful acknowledge sets the bit of `apr` indexed by the winner's priority, and the new running priority governs the next selection.
- R8: A local winner becomes active. If its level bit is 0 (edge), its pending bit is cleared. If its level bit is 1, its pending bit stays set.
- R9: An external winner raises `cmd_valid` with its ID, type and the current domain on the clock after the request. The command is held stable until `cmd_ready`, and the result word follows as an `ack_valid` pulse on the clock after acceptance.
- R10: Requests that arrive while a command is outstanding are ignored.
- R11: A `lcl_set` pulse in the same cycle that an edge acknowledge clears the same interrupt leaves it pending.
- R12: Local interrupts 0 to 127 are stored in two 64-bit words, interrupt n in word n/64 at bit n%64, and IDs above 63 behave the same as IDs below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_en | input | 1 | NMI enable for the current privilege level |
| dom | input | 2 | Current interrupt domain |
| ack_req | input | 1 | One-cycle acknowledge request |
| ack_nmi | input | 1 | Request variant: 1 = NMI, 0 = normal |
| ack_valid | output | 1 | Result strobe |
| ack_data | output | 64 | Result word |
| lcl_set | input | 128 | Set-pending pulses, one per local interrupt |
| lcl_en | input | 128 | Enable per local interrupt |
| lcl_level | input | 128 | Handling mode per local interrupt, 1 = level |
| lcl_prio | input | 640 | 5-bit priority per local interrupt, interrupt n at bits 5n+4:5n |
| ext_valid | input | 1 | External candidate present |
| ext_id | input | 24 | External candidate ID |
| ext_type | input | 3 | External candidate type |
| ext_prio | input | 5 | External candidate priority |
| cmd_valid | output | 1 | Activate command valid |
| cmd_ready | input | 1 | Activate command accepted |
| cmd_id | output | 24 | Command interrupt ID |
| cmd_type | output | 3 | Command interrupt type |
| cmd_dom | output | 2 | Command domain |
| lcl_pend | output | 128 | Local pending bits |
| lcl_act | output | 128 | Local active bits |
| apr | output | 32 | Active-priority register |

## Verification
A local, mismatched or empty acknowledge answers on the first clock after the request. The pending, active and `apr` outputs change on that same clock. An external winner shows `cmd_valid` one clock after the request, and its answer appears one clock after the clock on which `cmd_ready` was seen high. The bench drives inputs on falling edges. A behavioural model takes one step on each rising edge, and all outputs are compared with that model on the following falling edge, so every result is checked in exactly the cycle it is due.

// File: rtl/irq_ack_unit.sv
module irq_ack_unit #(
  parameter int NLOC = 128,
  parameter int PW   = 5,
  parameter int IDW  = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 nmi_en,
  input  logic [1:0]           dom,
  input  logic                 ack_req,
  input  logic                 ack_nmi,
  output logic                 ack_valid,
  output logic [63:0]          ack_data,
  input  logic [NLOC-1:0]      lcl_set,
  input  logic [NLOC-1:0]      lcl_en,
  input  logic [NLOC-1:0]      lcl_level,
  input  logic [NLOC*PW-1:0]   lcl_prio,
  input  logic                 ext_valid,
  input  logic [IDW-1:0]       ext_id,
  input  logic [2:0]           ext_type,
  input  logic [PW-1:0]        ext_prio,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [IDW-1:0]       cmd_id,
  output logic [2:0]           cmd_type,
  output logic [1:0]           cmd_dom,
  output logic [NLOC-1:0]      lcl_pend,
  output logic [NLOC-1:0]      lcl_act,
  output logic [(1<<PW)-1:0]   apr
);
  localparam int NPRIO  = 1 << PW;
  localparam int NWORDS = (NLOC + 63) / 64;
  localparam int LIW    = $clog2(NLOC);
  localparam logic [2:0] TYPE_LOCAL = 3'd1;

  logic [NWORDS-1:0][63:0] pend_q, act_q;
  logic [NPRIO-1:0] apr_q;
  logic busy_q;
  logic [63:0] held_q;

  logic [PW:0]    run_p;
  logic           loc_hit;
  logic [LIW-1:0] loc_id;
  logic [PW-1:0]  loc_p;

  always_comb begin
    run_p = (PW+1)'(NPRIO);
    for (int i = NPRIO - 1; i >= 0; i--)
      if (apr_q[i]) run_p = (PW+1)'(i);
  end

  always_comb begin
    loc_hit = 1'b0;
    loc_id  = '0;
    loc_p   = '1;
    for (int i = 0; i < NLOC; i++) begin
      if (pend_q[i/64][i%64] && lcl_en[i] && !act_q[i/64][i%64] &&
          (!loc_hit || lcl_prio[i*PW +: PW] < loc_p)) begin
        loc_hit = 1'b1;
        loc_id  = LIW'(i);
        loc_p   = lcl_prio[i*PW +: PW];
      end
    end
  end

  wire           ext_win  = ext_valid && (!loc_hit || ext_prio < loc_p);
  wire           win_hit  = loc_hit || ext_valid;
  wire [PW-1:0]  win_p    = ext_win ? ext_prio : loc_p;
  wire [2:0]     win_type = ext_win ? ext_type : TYPE_LOCAL;
  wire [IDW-1:0] win_id   = ext_win ? ext_id : IDW'(loc_id);
  wire           eligible = win_hit && ({1'b0, win_p} < run_p);
  wire           is_nmi   = (win_p == '0) && nmi_en;
  wire           accept   = eligible && (is_nmi == ack_nmi);
  wire           take     = !busy_q && ack_req && accept;
  wire           loc_take = take && !ext_win;
  wire [63:0]    result   = {31'b0, 1'b1, win_type, 5'b0, 24'(win_id)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      apr_q     <= '0;
      busy_q    <= 1'b0;
      held_q    <= '0;
      ack_valid <= 1'b0;
      ack_data  <= '0;
      cmd_valid <= 1'b0;
      cmd_id    <= '0;
      cmd_type  <= '0;
      cmd_dom   <= '0;
    end else begin
      ack_valid <= 1'b0;
      if (busy_q) begin
        if (cmd_ready) begin
          cmd_valid <= 1'b0;
          busy_q    <= 1'b0;
          ack_valid <= 1'b1;
          ack_data  <= held_q;
        end
      end else if (ack_req) begin
        if (!accept) begin
          ack_valid <= 1'b1;
          ack_data  <= '0;
        end else begin
          apr_q[win_p] <= 1'b1;
          if (ext_win) begin
            busy_q    <= 1'b1;
            cmd_valid <= 1'b1;
            cmd_id    <= ext_id;
            cmd_type  <= ext_type;
            cmd_dom   <= dom;
            held_q    <= result;
          end else begin
            ack_valid <= 1'b1;
            ack_data  <= result;
          end
        end
      end
    end
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    wire        hit_w = loc_take && ((int'(loc_id) / 64) == w);
    wire [63:0] bit_w = 64'd1 << loc_id[5:0];
    wire [63:0] lvl_w = 64'(lcl_level >> (w*64));
    wire [63:0] set_w = 64'(lcl_set >> (w*64));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[w] <= '0;
        act_q[w]  <= '0;
      end else begin
        pend_q[w] <= (pend_q[w] & ~(hit_w ? (bit_w & ~lvl_w) : 64'd0)) | set_w;
        act_q[w]  <= act_q[w] | (hit_w ? bit_w : 64'd0);
      end
    end
  end

  assign lcl_pend = NLOC'(pend_q);
  assign lcl_act  = NLOC'(act_q);
  assign apr      = apr_q;

  assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (ack_data[63:33] == '0 && ack_data[28:24] == '0));
  assert_valid_type_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_data[32]) |-> (ack_data[31:29] != 3'd0));
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !busy_q) |=> (ack_valid || cmd_valid));
  assert_apr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_data[32]) |-> (apr != '0));
  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_id) && $stable(cmd_type) && $stable(cmd_dom)));
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !cmd_ready) |=> ($stable(apr) && !ack_valid));
endmodule

// File: tb/tb_irq_ack_unit.sv
module tb_irq_ack_unit;
  logic clk = 0, rst_n = 0, nmi_en = 0, ack_req = 0, ack_nmi = 0;
  logic [1:0] dom = 0;
  logic ack_valid, cmd_valid, cmd_ready = 0;
  logic [63:0] ack_data;
  logic [127:0] lcl_set = 0, lcl_en = 0, lcl_level = 0, lcl_pend, lcl_act;
  logic [639:0] lcl_prio = 0;
  logic ext_valid = 0;
  logic [23:0] ext_id = 0, cmd_id;
  logic [2:0] ext_type = 0, cmd_type;
  logic [4:0] ext_prio = 0;
  logic [1:0] cmd_dom;
  logic [31:0] apr;

  int checks = 0, errors = 0;
  string cur = "R2";

  irq_ack_unit dut (.*);

  always #4 clk = ~clk;

  // behavioural reference model
  bit [127:0] m_pend, m_act;
  bit [31:0] m_apr;
  bit m_busy, m_cv, e_av;
  bit [63:0] e_ad, m_held;
  bit [23:0] m_cid;
  bit [2:0] m_ct;
  bit [1:0] m_cd;
  int bp, bid, bty, run;
  bit hit, exw, ok;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_act = 0; m_apr = 0; m_busy = 0; m_cv = 0; e_av = 0; e_ad = 0;
    end else begin
      hit = 0; exw = 0; bp = 99; bid = 0; bty = 1;
      for (int i = 0; i < 128; i++)
        if (m_pend[i] && lcl_en[i] && !m_act[i] && int'(lcl_prio[i*5 +: 5]) < bp) begin
          hit = 1; bp = int'(lcl_prio[i*5 +: 5]); bid = i;
        end
      if (ext_valid && int'(ext_prio) < bp) begin
        hit = 1; exw = 1; bp = int'(ext_prio); bid = int'(ext_id); bty = int'(ext_type);
      end
      run = 32;
      for (int p = 31; p >= 0; p--) if (m_apr[p]) run = p;
      e_av = 0;
      if (m_busy) begin
        if (cmd_ready) begin m_busy = 0; m_cv = 0; e_av = 1; e_ad = m_held; end
      end else if (ack_req) begin
        ok = hit && bp < run && ((bp == 0 && nmi_en) == ack_nmi);
        if (!ok) begin e_av = 1; e_ad = 0; end
        else begin
          m_apr[bp] = 1;
          if (exw) begin
            m_busy = 1; m_cv = 1; m_cid = ext_id; m_ct = ext_type; m_cd = dom;
            m_held = {31'b0, 1'b1, 3'(bty), 5'b0, 24'(bid)};
          end else begin
            m_act[bid] = 1;
            if (!lcl_level[bid]) m_pend[bid] = 0;
            e_av = 1; e_ad = {31'b0, 1'b1, 3'(bty), 5'b0, 24'(bid)};
          end
        end
      end
      m_pend = m_pend | lcl_set;
    end
  end

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk({cur, " ack_valid"}, 128'(ack_valid), 128'(e_av));
    if (e_av) chk({cur, " ack_data"}, 128'(ack_data), 128'(e_ad));
    chk({cur, " cmd_valid"}, 128'(cmd_valid), 128'(m_cv));
    if (m_cv) chk({cur, " cmd"}, 128'({cmd_id, cmd_type, cmd_dom}), 128'({m_cid, m_ct, m_cd}));
    chk({cur, " pend"}, lcl_pend, m_pend);
    chk({cur, " act"}, lcl_act, m_act);
    chk({cur, " apr"}, 128'(apr), 128'(m_apr));
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk); compare();
  endtask

  task automatic do_reset();
    rst_n = 0; cyc(); cyc(); rst_n = 1;
  endtask

  task automatic setl(int id, int pr, bit lvl);
    lcl_en[id] = 1; lcl_level[id] = lvl; lcl_prio[id*5 +: 5] = 5'(pr);
    lcl_set[id] = 1; cyc(); lcl_set[id] = 0;
  endtask

  task automatic ack(bit nmi);
    ack_req = 1; ack_nmi = nmi; cyc(); ack_req = 0; ack_nmi = 0;
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    cur = "R2";
    chk("R2 reset", {apr, ack_valid, cmd_valid}, 0);
    cyc();
    cur = "R3"; ack(0);
    chk("R3 empty", {ack_valid, ack_data}, {1'b1, 64'd0});
    cyc();

    cur = "R4";
    setl(5, 10, 0); setl(70, 3, 0);
    ack(0);
    chk("R4 R12 R1 lowest prio", ack_data, 64'h1_2000_0046);
    chk("R8 edge cleared", {lcl_pend[70], lcl_act[70]}, 2'b01);
    chk("R7 apr", apr, 32'h8);
    cur = "R5"; ack(0);
    chk("R5 blocked", ack_data, 0);

    do_reset(); cur = "R4";
    setl(9, 7, 0); setl(4, 7, 1);
    ack(0);
    chk("R4 tie lowest id", ack_data, 64'h1_2000_0004);
    chk("R8 level kept", {lcl_pend[4], lcl_act[4]}, 2'b11);

    do_reset(); cur = "R6";
    nmi_en = 1; setl(2, 0, 0);
    ack(0);
    chk("R6 normal on nmi", {ack_data, apr, lcl_pend[2]}, {64'd0, 32'd0, 1'b1});
    ack(1);
    chk("R6 nmi ack", ack_data, 64'h1_2000_0002);
    do_reset();
    nmi_en = 0; setl(2, 0, 0);
    ack(1);
    chk("R6 nmi on normal", {ack_data, lcl_act[2]}, {64'd0, 1'b0});
    ack(0);
    chk("R6 prio0 normal", ack_data, 64'h1_2000_0002);

    do_reset(); cur = "R9";
    dom = 2; setl(10, 9, 0);
    ext_valid = 1; ext_id = 24'h1234; ext_type = 3; ext_prio = 4;
    ack(0);
    chk("R9 cmd", {cmd_valid, ack_valid, cmd_id, cmd_type, cmd_dom}, {2'b10, 24'h1234, 3'd3, 2'd2});
    cur = "R10";
    ack_req = 1;
    for (int k = 0; k < 3; k++) cyc();
    ack_req = 0;
    chk("R10 ignored", {apr, lcl_act[10]}, {32'h10, 1'b0});
    cur = "R9"; cmd_ready = 1; cyc(); cmd_ready = 0; ext_valid = 0;
    chk("R9 answer after accept", {ack_valid, cmd_valid, ack_data}, {2'b10, 64'h1_6000_1234});
    cyc();

    do_reset(); cur = "R4";
    setl(20, 6, 0);
    ext_valid = 1; ext_id = 24'h55; ext_type = 2; ext_prio = 6;
    ack(0);
    chk("R4 local beats ext tie", ack_data, 64'h1_2000_0014);
    cur = "R5"; ack(0);
    chk("R5 equal to running", ack_data, 0);
    ext_valid = 0;

    do_reset(); cur = "R11";
    setl(30, 8, 0);
    lcl_set[30] = 1; ack(0); lcl_set[30] = 0;
    chk("R11 set wins", {lcl_pend[30], lcl_act[30], ack_data}, {2'b11, 64'h1_2000_001E});

    do_reset(); cur = "R12";
    setl(127, 1, 0);
    ack(0);
    chk("R12 top id", ack_data, 64'h1_2000_007F);
    cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule